// File: doc/BRIEF.md
# Conditional Acknowledge Interrupt Collector

This block collects eight single-bit status conditions into latched interrupt flags and drives one active-low interrupt pin. Each source has its own set event. Most sources are set by a rising edge. One link-health source is set by a falling edge. One source is the OR of a four-bit status group. Every source also has a release level, and its flag may only be cleared while the status sits at that level. Software enables individual sources with a mask. It acknowledges a flag by writing a one to it. The acknowledge is tested against the live status at that moment, so a condition that still persists keeps its flag, and the pin, asserted.

A small register port holds a mode bit, the mask and the flags. The collector acts only while the mode bit is one. While the mode bit is zero, the flags are frozen and the pin is held inactive. The energy-detect source powers up high, and its flag starts at one. That flag clears once the status falls and software acknowledges it.

Top module: `cond_ack_irq`

## Requirements
- R1: After reset the mode bit reads 0, the mask reads 0, the flags read 0x0080 and irq_n is 1.
- R2: While the mode bit is 0, status edges set no flag, acknowledge writes clear no flag, and irq_n stays 1.
- R3: Sources 1, 2, 3, 5, 6 and 7 take their status from stat_i[k-1]. Each sets flag bit k on a rising edge of its status and may clear only while that status is 0.
- R4: Source 4, the link source on stat_i[3], sets flag bit 4 on a falling edge and may clear only while stat_i[3] is 1. A rising edge of stat_i[3] sets nothing.
- R5: Source 8 sets flag bit 8 on a rising edge of the OR of grp_i. It may clear only while all four grp_i bits are 0.
- R6: Writing a 1 to a flag bit while that source's release level holds clears the flag on that clock edge. irq_n then returns to 1 if no other enabled flag is set.
- R7: Writing a 1 to a flag bit while the release level does not hold leaves the flag at 1 and leaves irq_n unchanged.
- R8: A 0 written to a flag bit has no effect. The bits of one acknowledge write are each evaluated independently.
- R9: irq_n is 0 exactly when the mode bit is 1 and some flag is set whose mask bit is also 1. Clearing a mask bit releases that source's hold on irq_n at once and keeps its flag.
- R10: The energy-detect source (source 7) is treated as high during reset, so its flag is 1 after reset and releasing reset creates no edge on any source.
- R11: Register map: address 0 bit 0 is the mode bit; address 1 bits 8:1 are the mask; address 2 bits 8:1 are the flags (write one to acknowledge). Every other bit and address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_i | input | 7 | Status levels of sources 1 to 7 |
| grp_i | input | 4 | Status group whose OR forms source 8 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions take the status inputs as already synchronous to clk, with one value per cycle. They take the register port as performing at most one write per cycle. The bench changes status and register inputs only at the falling edge and holds them through the next rising edge. Each table vector makes a single deliberate change, so the set event and the acknowledge outcome expected for that vector never depend on two conflicting changes.

// File: rtl/cai_pkg.sv
package cai_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_MASK = 2'd1,
    RA_FLAG = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/cai_edge.sv
module cai_edge #(
  parameter int          N        = 8,
  parameter logic [N-1:0] RST_LVL = '0,
  parameter logic [N-1:0] FALL_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] set_ev,
  output logic [N-1:0] clr_ok
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LVL;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    if (FALL_SEL[i]) begin : g_fall
      assign set_ev[i] = prev_q[i] & ~lvl[i];
      assign clr_ok[i] = lvl[i];
    end else begin : g_rise
      assign set_ev[i] = lvl[i] & ~prev_q[i];
      assign clr_ok[i] = ~lvl[i];
    end
  end
endmodule

// File: rtl/cai_flags.sv
module cai_flags #(
  parameter int           N        = 8,
  parameter logic [N-1:0] FLAG_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ok,
  input  logic [N-1:0] ack,
  output logic [N-1:0] flags_q
);
  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (en) flags_d = (flags_q & ~(ack & clr_ok)) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAG_RST;
    else        flags_q <= flags_d;
  end

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(flags_q));

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      (en && set_ev[i]) |=> flags_q[i]);
    a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (en && flags_q[i] && ack[i] && !clr_ok[i]) |=> flags_q[i]);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ack[i] && clr_ok[i] && !set_ev[i]) |=> !flags_q[i]);
    a_r8_noack: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ack[i] && !set_ev[i]) |=> (flags_q[i] == $past(flags_q[i])));
  end
endmodule

// File: rtl/cai_regs.sv
module cai_regs
  import cai_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  flags,
  output logic [DW-1:0] rdata,
  output logic          mode_q,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  ack
);
  logic [N-1:0] wfield;
  logic         unused_hi;

  assign wfield    = wdata[N:1];
  assign unused_hi = ^wdata[DW-1:N+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      mask_q <= '0;
    end else if (wr) begin
      if (addr == AW'(RA_CTRL)) mode_q <= wdata[0];
      if (addr == AW'(RA_MASK)) mask_q <= wfield;
    end
  end

  assign ack = (wr && addr == AW'(RA_FLAG)) ? wfield : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(RA_CTRL): rdata[0]   = mode_q;
      AW'(RA_MASK): rdata[N:1] = mask_q;
      AW'(RA_FLAG): rdata[N:1] = flags;
      default:      rdata      = '0;
    endcase
  end

  a_r11_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(RA_MASK)) |=> (mask_q == $past(wfield)));
  a_r11_mode_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(RA_CTRL)) |=> (mode_q == $past(wdata[0])));
endmodule

// File: rtl/cond_ack_irq.sv
module cond_ack_irq #(
  parameter int NSRC       = 8,
  parameter int GRP_W      = 4,
  parameter int DW         = 16,
  parameter int AW         = 2,
  parameter int LINK_IDX   = 3,
  parameter int ENERGY_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-2:0]   stat_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_n
);
  localparam logic [NSRC-1:0] ONE      = {{(NSRC-1){1'b0}}, 1'b1};
  localparam logic [NSRC-1:0] FALL_SEL = ONE << LINK_IDX;
  localparam logic [NSRC-1:0] RST_LVL  = ONE << ENERGY_IDX;

  logic [NSRC-1:0] lvl, set_ev, clr_ok, ack, flags, mask;
  logic            mode;

  assign lvl = {|grp_i, stat_i};

  cai_edge #(.N(NSRC), .RST_LVL(RST_LVL), .FALL_SEL(FALL_SEL)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .set_ev(set_ev), .clr_ok(clr_ok)
  );

  cai_flags #(.N(NSRC), .FLAG_RST(RST_LVL)) u_flags (
    .clk(clk), .rst_n(rst_n), .en(mode), .set_ev(set_ev), .clr_ok(clr_ok),
    .ack(ack), .flags_q(flags)
  );

  cai_regs #(.N(NSRC), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flags(flags), .rdata(reg_rdata), .mode_q(mode), .mask_q(mask), .ack(ack)
  );

  assign irq_n = ~(mode & |(flags & mask));

  a_r9_mask_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(1) && reg_wdata[NSRC:1] == '0) |=> irq_n);
  a_r2_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(0) && !reg_wdata[0]) |=> irq_n);
endmodule

// File: tb/cond_ack_irq_tb.sv
module cond_ack_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  stat_i = 7'h40;
  logic [3:0]  grp_i = 4'h0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq_n;
  int          nvec = 0;
  int          nerr = 0;

  always #4 clk = ~clk;

  cond_ack_irq u_dut (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .grp_i(grp_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // stat, grp, wr, addr, wdata, expected flags, expected irq_n
  localparam int NV = 23;
  localparam logic [46:0] VEC [NV] = '{
    {7'h41, 4'h0, 1'b0, 2'd0, 16'h0000, 16'h0080, 1'b1}, // R2 edge ignored
    {7'h41, 4'h0, 1'b1, 2'd2, 16'h0080, 16'h0080, 1'b1}, // R2 ack ignored
    {7'h40, 4'h0, 1'b1, 2'd0, 16'h0001, 16'h0080, 1'b1}, // R11 mode on
    {7'h40, 4'h0, 1'b1, 2'd1, 16'h01FE, 16'h0080, 1'b0}, // R9 mask all, R10
    {7'h40, 4'h0, 1'b1, 2'd2, 16'h0080, 16'h0080, 1'b0}, // R7 energy high
    {7'h00, 4'h0, 1'b1, 2'd2, 16'h0080, 16'h0000, 1'b1}, // R6 R10 cleared
    {7'h02, 4'h0, 1'b0, 2'd0, 16'h0000, 16'h0004, 1'b0}, // R3 src2 rise
    {7'h0A, 4'h0, 1'b0, 2'd0, 16'h0000, 16'h0004, 1'b0}, // R4 link rise no set
    {7'h02, 4'h0, 1'b0, 2'd0, 16'h0000, 16'h0014, 1'b0}, // R4 link fall
    {7'h02, 4'h0, 1'b1, 2'd2, 16'h0014, 16'h0014, 1'b0}, // R7 both held
    {7'h08, 4'h0, 1'b1, 2'd2, 16'h0004, 16'h0010, 1'b0}, // R8 independent
    {7'h08, 4'h0, 1'b1, 2'd2, 16'h0010, 16'h0000, 1'b1}, // R4 R6 link clear
    {7'h08, 4'h3, 1'b0, 2'd0, 16'h0000, 16'h0100, 1'b0}, // R5 group rise
    {7'h08, 4'h1, 1'b1, 2'd2, 16'h0100, 16'h0100, 1'b0}, // R5 one bit still high
    {7'h08, 4'h0, 1'b1, 2'd1, 16'h0000, 16'h0100, 1'b1}, // R9 mask drop keeps flag
    {7'h08, 4'h0, 1'b1, 2'd1, 16'h0100, 16'h0100, 1'b0}, // R9 re-enable
    {7'h08, 4'h0, 1'b1, 2'd2, 16'h0100, 16'h0000, 1'b1}, // R5 all low clears
    {7'h09, 4'h0, 1'b1, 2'd0, 16'h0000, 16'h0002, 1'b1}, // R2 mode off pin idle
    {7'h08, 4'h0, 1'b1, 2'd2, 16'h0002, 16'h0002, 1'b1}, // R2 ack frozen
    {7'h08, 4'h0, 1'b1, 2'd0, 16'h0001, 16'h0002, 1'b1}, // R9 masked out
    {7'h08, 4'h0, 1'b1, 2'd1, 16'h0002, 16'h0002, 1'b0}, // R9 unmask
    {7'h08, 4'h0, 1'b1, 2'd2, 16'h0000, 16'h0002, 1'b0}, // R8 zero write
    {7'h08, 4'h0, 1'b1, 2'd2, 16'h0002, 16'h0000, 1'b1}  // R3 R6 src1 clear
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [15:0] exp);
    reg_wr   = 1'b0;
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd(2'd0, "R1 mode", 16'h0000);
    rd(2'd1, "R1 mask", 16'h0000);
    rd(2'd2, "R10 flags", 16'h0080);
    rd(2'd3, "R11 spare", 16'h0000);
    check("R1 irq_n", {15'h0, irq_n}, 16'h0001);
    for (int i = 0; i < NV; i++) begin
      stat_i    = VEC[i][46:40];
      grp_i     = VEC[i][39:36];
      reg_wr    = VEC[i][35];
      reg_addr  = VEC[i][34:33];
      reg_wdata = VEC[i][32:17];
      @(posedge clk);
      @(negedge clk);
      rd(2'd2, $sformatf("vec%0d flags", i), VEC[i][16:1]);
      check($sformatf("vec%0d irq_n", i), {15'h0, irq_n}, {15'h0, VEC[i][0]});
    end
    rd(2'd0, "R11 mode readback", 16'h0001);
    rd(2'd1, "R11 mask readback", 16'h0002);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nvec++;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule